// File: doc/BRIEF.md
# Two-State Iterative Fibonacci Engine

This block computes the Fibonacci number F(n) for an unsigned index n. A one-cycle start strobe, sampled while the engine is idle, captures n. The engine then advances a pair of working registers by one Fibonacci step on every clock until a down-counter reaches 1. The sequence is F(0)=0, F(1)=1 and F(n)=F(n-1)+F(n-2) for n>1.

The controller has two states, idle and compute. The done flag and the result are combinational decodes of the state and the working registers, so neither output has a flip-flop of its own. A caller pulses start, waits for done, and takes the result in the cycle in which done is high.

Top module: `fib_iter`

## Requirements
- R1: While rst_n is low, and after it is released with no start, the engine is idle and done is low. The reset is asynchronous and active low, and it clears the counter and both working registers.
- R2: In the idle state done stays low, and the engine stays idle until start is sampled high on a rising clock edge.
- R3: In the cycle where done is high, result equals F(n) modulo 2^16 for every index n from 1 to 31, with additions wrapping at 16 bits (for example, n=25 gives 9489).
- R4: done is high for exactly one cycle per computation. It first rises n-1 rising edges after the edge that sampled start, so for n=1 it is high right after that edge.
- R5: On the rising edge that ends the done cycle the engine returns to idle: done is low in the next cycle and stays low until a new start is sampled.
- R6: start is ignored while the engine is computing, including during the done cycle. The result and the done timing are those of the index that was captured.
- R7: n_idx is sampled only on the edge that accepts start. Changes to it during a computation have no effect on the result.
- R8: A start sampled in the first idle cycle after a done cycle begins a new computation from fresh register values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, accepted only when idle |
| n_idx | input | 5 | Fibonacci index n, sampled with start |
| result | output | 16 | F(n) modulo 2^16, valid while done is high |
| done | output | 1 | High for one cycle when result is valid |

## Verification
Every index from 1 to 31 is run on its own, from n=1 (done right after the load edge) up to indices above 24, where the 16-bit sum wraps. That sweep separates a wrong seed or wrong update order from a wrong stop condition. A second sweep repeats every index while start and a conflicting index are held high during the computation, to expose a controller that reloads while busy. Back-to-back starts issued in the first idle cycle, long idle gaps with no start, and a reset in the middle of a computation check that the engine restarts cleanly and never reports a stale done.

// File: rtl/fib_iter.sv
module fib_iter #(
  parameter int IDX_W = 5,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] n_idx,
  output logic [RES_W-1:0] result,
  output logic             done
);

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_t;

  st_t              state;
  logic [IDX_W-1:0] count;
  logic [RES_W-1:0] acc_hi, acc_lo;
  logic             busy;
  logic             more;

  assign busy   = (state == ST_RUN);
  assign more   = (count > IDX_W'(1));
  assign done   = busy && !more;
  assign result = acc_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      count  <= '0;
      acc_hi <= '0;
      acc_lo <= '0;
    end else begin
      case (state)
        ST_IDLE:
          if (start) begin
            count  <= n_idx;
            acc_hi <= RES_W'(1);
            acc_lo <= '0;
            state  <= ST_RUN;
          end
        ST_RUN:
          if (more) begin
            count  <= count - IDX_W'(1);
            acc_hi <= acc_hi + acc_lo;
            acc_lo <= acc_hi;
          end else begin
            state  <= ST_IDLE;
          end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fib_iter_chk.sv
module fib_iter_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [IDX_W-1:0] n_idx,
  input logic             done,
  input logic             busy,
  input logic [IDX_W-1:0] count
);

  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!done);
  end

  assert_idle_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!busy && !done));

  assert_load_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && count == $past(n_idx)));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_done_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

bind fib_iter fib_iter_chk #(.IDX_W(IDX_W)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .n_idx (n_idx),
  .done  (done),
  .busy  (busy),
  .count (count)
);

// File: tb/fib_iter_tb_top.sv
`timescale 1ns/1ps
module fib_iter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  n_idx = '0;
  logic [15:0] result;
  logic        done;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  fib_iter dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .n_idx(n_idx), .result(result), .done(done)
  );

  function automatic logic [15:0] fib_ref(input int n);
    logic [15:0] a, b, t;
    a = 16'd0; b = 16'd1;
    for (int i = 0; i < n; i++) begin
      t = a + b; a = b; b = t;
    end
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Launch one computation; disturb drives start and a different index while busy.
  task automatic run_one(input int n, input bit disturb);
    int k;
    @(negedge clk);
    start = 1'b1;
    n_idx = 5'(n);
    @(posedge clk); #1;
    start = 1'b0;
    n_idx = 5'(~n);
    k = 0;
    while (!done && k < 40) begin
      if (disturb && (k + 1) < (n - 1)) begin
        start = 1'b1; n_idx = 5'd3;
      end else begin
        start = 1'b0;
      end
      @(posedge clk); #1;
      k++;
    end
    start = 1'b0;
    chk(k == n - 1, disturb ? "R4/R6 latency" : "R4 latency", k, n - 1);
    chk(result == fib_ref(n), disturb ? "R3/R6/R7 result" : "R3 result", result, fib_ref(n));
    @(posedge clk); #1;
    chk(done == 1'b0, "R4/R5 done single cycle", done, 0);
  endtask

  initial begin
    #800000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1;
    chk(done == 1'b0, "R1 done in reset", done, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(done == 1'b0, "R1 done held in reset", done, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      chk(done == 1'b0, "R1/R2 idle without start", done, 0);
    end

    for (int n = 1; n < 32; n++) run_one(n, 1'b0);
    for (int n = 1; n < 32; n++) run_one(n, 1'b1);

    // R5: after a done cycle nothing happens without a new start.
    run_one(7, 1'b0);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      chk(done == 1'b0, "R5 stays idle", done, 0);
    end

    // R8: start in the first idle cycle right after done.
    @(negedge clk); start = 1'b1; n_idx = 5'd10;
    @(posedge clk); #1; start = 1'b0;
    for (int i = 0; i < 20 && !done; i++) begin @(posedge clk); #1; end
    chk(result == fib_ref(10), "R8 first run", result, fib_ref(10));
    start = 1'b1; n_idx = 5'd12;
    @(posedge clk); #1;
    start = 1'b0;
    chk(done == 1'b0, "R8 done cleared", done, 0);
    @(posedge clk); #1;
    start = 1'b1;
    for (int i = 0; i < 20 && !done; i++) begin @(posedge clk); #1; end
    chk(result == fib_ref(12), "R8 back-to-back result", result, fib_ref(12));
    start = 1'b0;
    @(posedge clk); #1;

    // R1: reset in the middle of a computation.
    @(negedge clk); start = 1'b1; n_idx = 5'd20;
    @(posedge clk); #1; start = 1'b0;
    repeat (4) @(posedge clk);
    #1; rst_n = 1'b0;
    #1;
    chk(done == 1'b0, "R1 async reset mid-run", done, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(posedge clk); #1;
      chk(done == 1'b0, "R1 no stale done after reset", done, 0);
    end
    run_one(24, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule